// File: doc/BRIEF.md
# Direct-Mapped TLB Address Translator

This block maps 32-bit virtual byte addresses onto 32-bit physical byte addresses for a memory organised in 4 KB pages. The low 12 address bits are the offset within a page and pass straight through. The upper 20 bits form the virtual page number, and that number is replaced by a 20-bit physical page number. The mapping comes from a 16-entry, direct-mapped translation buffer. The four lowest page-number bits choose the entry, and the remaining 16 bits are held as the entry's tag.

When a lookup misses, the block reads one 32-bit page-table entry through a memory read port. The entry's address is the page-table base plus four times the virtual page number. If that entry is valid, the block installs it in the buffer and returns the translation. If it is not valid, the block reports a page fault. A write to a page marked read-only is refused with a protection fault, on both the hit path and the walk path. Each fault records the virtual page number that caused it.

Software can place entries in the buffer directly through a load port. A flush input clears every entry in a single cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, rsp_valid_o, mem_rd_req_o and fault_vpn_o are 0, req_ready_o is 1, and every buffer entry is invalid, so the first request always misses.
- R2: A request that hits a valid entry is answered one cycle after it is accepted, with rsp_hit_o=1 and rsp_paddr_o equal to the entry's physical page number concatenated with vaddr[11:0].
- R3: vaddr[15:12] selects the buffer entry and vaddr[31:16] must equal the stored tag. Two pages that share an index but differ in tag replace each other.
- R4: On a miss, mem_rd_req_o rises in the cycle after acceptance, with mem_rd_addr_o = pt_base_i + 4*vaddr[31:12]. The address holds steady until mem_rd_valid_i arrives, and req_ready_o stays 0 for the whole walk.
- R5: A page-table entry uses bit 0 as valid, bit 1 as writable and bits [31:12] as the physical page number. A valid entry produces a response one cycle after mem_rd_valid_i, with rsp_hit_o=0 and the translated address, and is installed so that a later access to that page hits.
- R6: A page-table entry with bit 0 clear produces rsp_page_fault_o=1 and is not installed, so a repeat access walks again.
- R7: A write to a page whose writable bit is 0 produces rsp_prot_fault_o=1, whether the entry hits or comes from a walk. Reads of that page and writes to writable pages raise no fault.
- R8: fault_vpn_o takes the virtual page number of every response that carries a fault and keeps its value across responses that carry none.
- R9: A one-cycle flush_i pulse invalidates all entries. In the same cycle it takes precedence over a software load.
- R10: ld_en_i writes a valid entry at index ld_vpn_i[3:0], with tag ld_vpn_i[19:4], physical page number ld_ppn_i and writable flag ld_writable_i. Later accesses to that page hit with that mapping.
- R11: Hits can follow each other every cycle. req_ready_o stays 1, and each response appears one cycle after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all buffer entries |
| pt_base_i | input | 32 | Page-table base byte address |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Block can accept a request |
| req_vaddr_i | input | 32 | Virtual byte address |
| req_write_i | input | 1 | Request is a write access |
| rsp_valid_o | output | 1 | Response valid, one cycle pulse |
| rsp_hit_o | output | 1 | Translation came from the buffer |
| rsp_paddr_o | output | 32 | Physical byte address |
| rsp_page_fault_o | output | 1 | Page-table entry was invalid |
| rsp_prot_fault_o | output | 1 | Write to read-only page |
| fault_vpn_o | output | 20 | Page number of last faulting request |
| mem_rd_req_o | output | 1 | Page-table read request |
| mem_rd_addr_o | output | 32 | Page-table entry address |
| mem_rd_valid_i | input | 1 | Page-table read data valid |
| mem_rd_data_i | input | 32 | Page-table entry |
| ld_en_i | input | 1 | Software entry load strobe |
| ld_vpn_i | input | 20 | Virtual page number to load |
| ld_ppn_i | input | 20 | Physical page number to load |
| ld_writable_i | input | 1 | Writable flag to load |

## Verification
The checks assume three things about the inputs. The memory side pulses mem_rd_valid_i only while a page-table read is outstanding. The requester offers a request only when req_ready_o is high, since an offer made while the block is busy is dropped. The response is taken in the cycle it appears. The bench's memory model keeps to this: it answers a read only while mem_rd_req_o is high, a fixed two cycles later and for exactly one cycle, and the bench waits for each response before it issues the next request, except for the deliberate back-to-back hit pair.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W      = 32;
  localparam int unsigned PA_W      = 32;
  localparam int unsigned PAGE_W    = 12;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned PTE_V_BIT = 0;
  localparam int unsigned PTE_W_BIT = 1;

  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_WAIT = 1'b1
  } walk_state_e;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned PPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [PPN_W-1:0] rd_ppn_o,
  output logic             rd_wr_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic             wr_perm_i
);
  localparam int unsigned N = 1 << IDX_W;

  logic [N-1:0]       valid_vec;
  logic [N-1:0]       perm_vec;
  logic [N*TAG_W-1:0] tag_flat;
  logic [N*PPN_W-1:0] ppn_flat;

  for (genvar g = 0; g < N; g++) begin : g_entry
    logic             v_q;
    logic             w_q;
    logic [TAG_W-1:0] t_q;
    logic [PPN_W-1:0] p_q;
    logic             sel;

    assign sel = we_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        w_q <= 1'b0;
        t_q <= '0;
        p_q <= '0;
      end else if (flush_i) begin
        v_q <= 1'b0;
      end else if (sel) begin
        v_q <= 1'b1;
        w_q <= wr_perm_i;
        t_q <= wr_tag_i;
        p_q <= wr_ppn_i;
      end
    end

    assign valid_vec[g]              = v_q;
    assign perm_vec[g]               = w_q;
    assign tag_flat[g*TAG_W +: TAG_W] = t_q;
    assign ppn_flat[g*PPN_W +: PPN_W] = p_q;
  end

  assign rd_valid_o = valid_vec[rd_idx_i];
  assign rd_wr_o    = perm_vec[rd_idx_i];
  assign rd_tag_o   = tag_flat[rd_idx_i*TAG_W +: TAG_W];
  assign rd_ppn_o   = ppn_flat[rd_idx_i*PPN_W +: PPN_W];
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned PAGE_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VA_W-1:0] vaddr_i,
  input  logic            write_i,
  input  logic [PA_W-1:0] pt_base_i,
  output logic            mem_rd_req_o,
  output logic [PA_W-1:0] mem_rd_addr_o,
  input  logic            mem_rd_valid_i,
  input  logic [PA_W-1:0] mem_rd_data_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [VA_W-1:0] vaddr_o,
  output logic            write_o,
  output logic [PA_W-1:0] pte_o
);
  localparam int unsigned VPN_W = VA_W - PAGE_W;

  walk_state_e     state_q;
  logic [VA_W-1:0] vaddr_q;
  logic            write_q;
  logic [PA_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WALK_IDLE;
      vaddr_q <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        WALK_IDLE: if (start_i) begin
          state_q <= WALK_WAIT;
          vaddr_q <= vaddr_i;
          write_q <= write_i;
          // 4-byte entries indexed by page number
          addr_q  <= pt_base_i + PA_W'({vaddr_i[VA_W-1 -: VPN_W], 2'b00});
        end
        WALK_WAIT: if (mem_rd_valid_i) state_q <= WALK_IDLE;
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q == WALK_WAIT);
  assign mem_rd_req_o  = busy_o;
  assign mem_rd_addr_o = addr_q;
  assign done_o        = busy_o && mem_rd_valid_i;
  assign vaddr_o       = vaddr_q;
  assign write_o       = write_q;
  assign pte_o         = mem_rd_data_i;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W   = tlb_pkg::VA_W,
  parameter int unsigned PA_W   = tlb_pkg::PA_W,
  parameter int unsigned PAGE_W = tlb_pkg::PAGE_W,
  parameter int unsigned IDX_W  = tlb_pkg::IDX_W,
  localparam int unsigned VPN_W = VA_W - PAGE_W,
  localparam int unsigned PPN_W = PA_W - PAGE_W,
  localparam int unsigned TAG_W = VPN_W - IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [PA_W-1:0]  pt_base_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_page_fault_o,
  output logic             rsp_prot_fault_o,
  output logic [VPN_W-1:0] fault_vpn_o,
  output logic             mem_rd_req_o,
  output logic [PA_W-1:0]  mem_rd_addr_o,
  input  logic             mem_rd_valid_i,
  input  logic [PA_W-1:0]  mem_rd_data_i,
  input  logic             ld_en_i,
  input  logic [VPN_W-1:0] ld_vpn_i,
  input  logic [PPN_W-1:0] ld_ppn_i,
  input  logic             ld_writable_i
);
  logic             walk_busy, walk_done, walk_write;
  logic [VA_W-1:0]  walk_vaddr;
  logic [PA_W-1:0]  pte;
  logic             lk_valid, lk_wr, lk_hit;
  logic [TAG_W-1:0] lk_tag;
  logic [PPN_W-1:0] lk_ppn;
  logic             accept, hit_acc, walk_start;
  logic             pte_v, pte_w, install;
  logic [PPN_W-1:0] pte_ppn;
  logic             we;
  logic [IDX_W-1:0] w_idx;
  logic [TAG_W-1:0] w_tag;
  logic [PPN_W-1:0] w_ppn;
  logic             w_perm;
  logic             unused_pte_bits;

  assign req_ready_o = !walk_busy;
  assign accept      = req_valid_i && !walk_busy;

  tlb_entry_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .rd_idx_i   (req_vaddr_i[PAGE_W +: IDX_W]),
    .rd_valid_o (lk_valid),
    .rd_tag_o   (lk_tag),
    .rd_ppn_o   (lk_ppn),
    .rd_wr_o    (lk_wr),
    .we_i       (we),
    .wr_idx_i   (w_idx),
    .wr_tag_i   (w_tag),
    .wr_ppn_i   (w_ppn),
    .wr_perm_i  (w_perm)
  );

  assign lk_hit     = lk_valid && (lk_tag == req_vaddr_i[VA_W-1 -: TAG_W]);
  assign hit_acc    = accept && lk_hit;
  assign walk_start = accept && !lk_hit;

  tlb_walker #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W)) u_walker (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (walk_start),
    .vaddr_i        (req_vaddr_i),
    .write_i        (req_write_i),
    .pt_base_i      (pt_base_i),
    .mem_rd_req_o   (mem_rd_req_o),
    .mem_rd_addr_o  (mem_rd_addr_o),
    .mem_rd_valid_i (mem_rd_valid_i),
    .mem_rd_data_i  (mem_rd_data_i),
    .busy_o         (walk_busy),
    .done_o         (walk_done),
    .vaddr_o        (walk_vaddr),
    .write_o        (walk_write),
    .pte_o          (pte)
  );

  assign pte_v   = pte[PTE_V_BIT];
  assign pte_w   = pte[PTE_W_BIT];
  assign pte_ppn = pte[PA_W-1 -: PPN_W];
  assign unused_pte_bits = ^pte[PAGE_W-1:2];
  assign install = walk_done && pte_v;

  // walk refill wins over software load; flush wins over both inside the array
  assign we     = install || ld_en_i;
  assign w_idx  = install ? walk_vaddr[PAGE_W +: IDX_W]  : ld_vpn_i[IDX_W-1:0];
  assign w_tag  = install ? walk_vaddr[VA_W-1 -: TAG_W]  : ld_vpn_i[VPN_W-1 -: TAG_W];
  assign w_ppn  = install ? pte_ppn                      : ld_ppn_i;
  assign w_perm = install ? pte_w                        : ld_writable_i;

  logic prot_hit, prot_walk, pf_walk;
  assign prot_hit  = req_write_i && !lk_wr;
  assign pf_walk   = !pte_v;
  assign prot_walk = pte_v && walk_write && !pte_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o      <= 1'b0;
      rsp_hit_o        <= 1'b0;
      rsp_paddr_o      <= '0;
      rsp_page_fault_o <= 1'b0;
      rsp_prot_fault_o <= 1'b0;
      fault_vpn_o      <= '0;
    end else begin
      rsp_valid_o <= hit_acc || walk_done;
      if (hit_acc) begin
        rsp_hit_o        <= 1'b1;
        rsp_paddr_o      <= {lk_ppn, req_vaddr_i[PAGE_W-1:0]};
        rsp_page_fault_o <= 1'b0;
        rsp_prot_fault_o <= prot_hit;
        if (prot_hit) fault_vpn_o <= req_vaddr_i[VA_W-1 -: VPN_W];
      end else if (walk_done) begin
        rsp_hit_o        <= 1'b0;
        rsp_paddr_o      <= {pte_ppn, walk_vaddr[PAGE_W-1:0]};
        rsp_page_fault_o <= pf_walk;
        rsp_prot_fault_o <= prot_walk;
        if (pf_walk || prot_walk) fault_vpn_o <= walk_vaddr[VA_W-1 -: VPN_W];
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned VPN_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic             rsp_hit_o,
  input logic             rsp_page_fault_o,
  input logic             rsp_prot_fault_o,
  input logic [VPN_W-1:0] fault_vpn_o,
  input logic             mem_rd_req_o,
  input logic [PA_W-1:0]  mem_rd_addr_o,
  input logic             mem_rd_valid_i
);
  // R4
  walk_blocks_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o |-> !req_ready_o);

  // R4
  walk_addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o && $past(mem_rd_req_o) && !$past(mem_rd_valid_i) |-> $stable(mem_rd_addr_o));

  // R2
  accept_progress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o || mem_rd_req_o);

  // R5
  walk_answer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o && mem_rd_valid_i |=> rsp_valid_o && !rsp_hit_o);

  // R6
  hit_no_page_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> !rsp_page_fault_o);

  // R7
  single_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_page_fault_o && rsp_prot_fault_o));

  // R8
  fault_vpn_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fault_vpn_o) |-> rsp_valid_o && (rsp_page_fault_o || rsp_prot_fault_o));
endmodule

bind tlb_xlate tlb_xlate_chk #(.PA_W(PA_W), .VPN_W(VPN_W)) u_chk (.*);

// File: tb/tlb_xlate_tb_top.sv
`timescale 1ns/1ps
module tlb_xlate_tb_top;
  localparam logic [31:0] PT_BASE = 32'h0010_0000;
  // {vaddr, write, exp_hit, exp_page_fault, exp_prot_fault}
  localparam logic [35:0] VEC [12] = '{
    {32'h12345678, 4'b0000}, {32'h12345ABC, 4'b1100},
    {32'h22346010, 4'b0000}, {32'h22346020, 4'b1101},
    {32'h32345000, 4'b0000}, {32'h12345004, 4'b0000},
    {32'h000FF000, 4'b0010}, {32'h000FF000, 4'b0010},
    {32'h44447FFF, 4'b1000}, {32'h55558001, 4'b1001},
    {32'h55558002, 4'b0100}, {32'h12345008, 4'b0100}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic mem_valid = 1'b0;
  logic [31:0] mem_data = '0;
  logic ld_en = 1'b0, ld_wr = 1'b0;
  logic [19:0] ld_vpn = '0, ld_ppn = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_pf, rsp_prot, mem_req;
  logic [31:0] rsp_paddr, mem_addr;
  logic [19:0] fault_vpn;

  int checks = 0, errors = 0;
  logic [31:0] mem_addr_seen = '0;
  bit mem_seen = 0;
  bit ready_during_walk = 0;
  logic [19:0] exp_fault_vpn = '0;

  always #4 clk = ~clk;

  tlb_xlate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .pt_base_i(PT_BASE),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit),
    .rsp_paddr_o(rsp_paddr), .rsp_page_fault_o(rsp_pf), .rsp_prot_fault_o(rsp_prot),
    .fault_vpn_o(fault_vpn), .mem_rd_req_o(mem_req), .mem_rd_addr_o(mem_addr),
    .mem_rd_valid_i(mem_valid), .mem_rd_data_i(mem_data), .ld_en_i(ld_en),
    .ld_vpn_i(ld_vpn), .ld_ppn_i(ld_ppn), .ld_writable_i(ld_wr)
  );

  function automatic logic [31:0] pte_of(input logic [19:0] vpn);
    if (vpn[7:0] == 8'hFF) return 32'h0;
    return {vpn ^ 20'hA5A5A, 10'b0, vpn[0], 1'b1};
  endfunction

  function automatic logic [31:0] xl(input logic [31:0] va);
    return {va[31:12] ^ 20'hA5A5A, va[11:0]};
  endfunction

  // page-table memory: answers two cycles into a request, for one cycle
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_valid) begin
        mem_valid = 1'b0;
        cnt = 0;
      end else if (mem_req) begin
        mem_seen = 1;
        mem_addr_seen = mem_addr;
        if (req_ready) ready_during_walk = 1;
        cnt++;
        if (cnt >= 2) begin
          mem_valid = 1'b1;
          mem_data = pte_of(20'((mem_addr - PT_BASE) >> 2));
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] va, input bit wr, output int lat);
    mem_seen = 0;
    ready_during_walk = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 30) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_fault_vpn(input logic [31:0] va, input string req);
    if (rsp_pf || rsp_prot) exp_fault_vpn = va[31:12];
    @(negedge clk);
    chk(fault_vpn == exp_fault_vpn, req, "fault_vpn", 32'(fault_vpn), 32'(exp_fault_vpn));
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 1);
    chk(mem_req == 1'b0, "R1", "mem_req", 32'(mem_req), 0);
    chk(fault_vpn == 20'h0, "R1", "fault_vpn", 32'(fault_vpn), 0);
    rst_n = 1'b1;

    // R3 R5 R6 R7 via the vector table
    for (int k = 0; k < 12; k++) begin
      logic [31:0] va;
      bit wr, eh, epf, eprot;
      va = VEC[k][35:4]; wr = VEC[k][3]; eh = VEC[k][2]; epf = VEC[k][1]; eprot = VEC[k][0];
      do_req(va, wr, lat);
      chk(rsp_valid, "R5", "response seen", 32'(rsp_valid), 1);
      chk(rsp_hit == eh, "R3", "hit", 32'(rsp_hit), 32'(eh));
      chk(rsp_pf == epf, "R6", "page_fault", 32'(rsp_pf), 32'(epf));
      chk(rsp_prot == eprot, "R7", "prot_fault", 32'(rsp_prot), 32'(eprot));
      if (!epf) chk(rsp_paddr == xl(va), "R2", "paddr", rsp_paddr, xl(va));
      if (eh) chk(lat == 1 && !mem_seen, "R2", "hit latency", 32'(lat), 1);
      else begin
        chk(mem_addr_seen == PT_BASE + {10'b0, va[31:12], 2'b00}, "R4", "pte addr",
            mem_addr_seen, PT_BASE + {10'b0, va[31:12], 2'b00});
        chk(!ready_during_walk, "R4", "ready during walk", 32'(ready_during_walk), 0);
      end
      check_fault_vpn(va, "R8");
    end

    // R9 flush empties the buffer
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    do_req(32'h1234500C, 1'b0, lat);
    chk(rsp_hit == 1'b0 && mem_seen, "R9", "miss after flush", 32'(rsp_hit), 0);

    // R10 software load, read and write
    @(negedge clk);
    ld_en = 1'b1; ld_vpn = 20'h9999A; ld_ppn = 20'h00ABC; ld_wr = 1'b0;
    @(negedge clk); ld_en = 1'b0;
    do_req(32'h9999A123, 1'b0, lat);
    chk(rsp_hit == 1'b1, "R10", "loaded hit", 32'(rsp_hit), 1);
    chk(rsp_paddr == 32'h00ABC123, "R10", "loaded paddr", rsp_paddr, 32'h00ABC123);
    do_req(32'h9999A124, 1'b1, lat);
    chk(rsp_prot == 1'b1, "R7", "prot on loaded ro page", 32'(rsp_prot), 1);
    check_fault_vpn(32'h9999A124, "R8");

    // R11 back-to-back hits
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_vaddr = 32'h9999A001;
    @(negedge clk);
    chk(rsp_valid && rsp_hit && rsp_paddr == 32'h00ABC001, "R11", "first paddr", rsp_paddr, 32'h00ABC001);
    chk(req_ready == 1'b1, "R11", "ready", 32'(req_ready), 1);
    req_vaddr = 32'h1234500C;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_hit && rsp_paddr == xl(32'h1234500C), "R11", "second paddr",
        rsp_paddr, xl(32'h1234500C));

    // R9 flush wins over a same-cycle load
    @(negedge clk);
    flush = 1'b1; ld_en = 1'b1; ld_vpn = 20'h9999B; ld_ppn = 20'h00111; ld_wr = 1'b1;
    @(negedge clk); flush = 1'b0; ld_en = 1'b0;
    do_req(32'h9999B000, 1'b0, lat);
    chk(rsp_hit == 1'b0, "R9", "load dropped under flush", 32'(rsp_hit), 0);
    chk(rsp_paddr == xl(32'h9999B000), "R9", "walk paddr", rsp_paddr, xl(32'h9999B000));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule